// File: doc/BRIEF.md
# Tone-Pair Audio Demodulator with Bit-Clock Recovery

This block turns a stream of signed 8-bit audio samples into a stream of recovered data bits. The audio carries two tones (nominally 1200 Hz and 2200 Hz) at 9600 samples per second. Data runs at 1200 bits per second, so each bit spans exactly eight samples. A sample is accepted on every clock cycle where `smp_en` is high. About once per eight accepted samples the block raises `bit_valid` for one cycle, with the decoded data bit on `bit_out`.

Tone discrimination multiplies each sample by the sample from half a bit earlier. The product is smoothed by a first-order recursive lowpass whose coefficients are plain shifts and adds. The sign of the smoothed value forms a two-level signal. A fractional bit-phase counter tracks bit timing: it advances every sample and is pulled one step toward the bit centre whenever the two-level signal toggles. When the counter wraps, a majority of the last three sliced samples gives the line bit. The data bit is 1 when the line bit repeats and 0 when it changes. A mode input swaps the lowpass feedback for a single-shift variant. Frame parsing, gain control and the converter are outside the block.

Top module: `afsk_demod_sync`

## Requirements
- R1: After a synchronous reset `bit_valid` and `bit_out` are 0. With no sliced edges, the first strobe follows the 8th accepted sample.
- R2: Cycles with `smp_en` low change no state. On such a cycle `bit_valid` is never raised, and the following samples decode as if the idle cycle had not occurred.
- R3: The discriminator output is (sample × sample accepted 4 enables earlier) arithmetically shifted right by 2. Before 4 samples have arrived, the older operand is 0. Signed values use two's complement.
- R4: With `fb_sel`=0 the filter computes y = xprev + x + (yprev>>>1) + (yprev>>>3) + (yprev>>>5) in 16-bit signed arithmetic. Here x is the discriminator output, and xprev and yprev hold the previous sample's values, both starting at 0.
- R5: With `fb_sel`=1 the feedback term is only yprev>>>1.
- R6: Each sample shifts the bit (y > 0) into a history. An edge is present when the newest history bit differs from the one before it. The history starts at 0.
- R7: The phase counter starts at 0 and runs modulo 64. On an edge it first adds 1 if it is below 32 and otherwise subtracts 1. It then adds 8 every accepted sample, and a wrap happens when the sum reaches 64 or more.
- R8: On a wrap the line bit is 1 when at least two of the three newest history bits, counting this sample's, are 1.
- R9: On a wrap `bit_valid` is high for exactly the cycle after the accepting enable. `bit_out` is 1 if the line bit equals the previous line bit and 0 otherwise; the previous line bit starts at 0. `bit_out` holds between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_en | input | 1 | Accept `smp_in` this cycle |
| smp_in | input | 8 | Signed audio sample |
| fb_sel | input | 1 | 0: three-shift feedback, 1: single-shift feedback |
| bit_valid | output | 1 | One-cycle strobe per recovered bit |
| bit_out | output | 1 | Decoded data bit |

## Verification
A silent input pins down the free-running bit clock: it gives the first-strobe position and a steady run of repeated line bits. Constant and extreme-amplitude inputs separate the delay alignment, the shift of the product and its sign handling. Two-tone streams carrying differentially coded random data, started at an odd sample offset, drive the edge nudges, the vote and the line-bit decoding under both feedback modes. A random-sample stream with random idle gaps shows that idle cycles are invisible to the decoded result.

// File: rtl/afsk_demod_pkg.sv
package afsk_demod_pkg;

   // two-of-three majority over the newest sliced samples
   function automatic logic vote3(input logic [2:0] h);
      return (h[0] & h[1]) | (h[0] & h[2]) | (h[1] & h[2]);
   endfunction

endpackage

// File: rtl/afsk_delay_mult.sv
module afsk_delay_mult #(
   parameter int SAMPLE_W   = 8,
   parameter int LAG        = 4,
   parameter int PROD_SHIFT = 2,
   parameter int OUT_W      = 16
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       en,
   input  logic signed [SAMPLE_W-1:0] smp_in,
   output logic signed [OUT_W-1:0]    prod_out
);
   localparam int FULL_W = 2 * SAMPLE_W;

   logic signed [SAMPLE_W-1:0] tap [LAG];
   logic signed [FULL_W-1:0]   full_prod;
   logic signed [FULL_W-1:0]   shifted;

   generate
      for (genvar i = 0; i < LAG; i++) begin : g_tap
         always_ff @(posedge clk) begin
            if (rst)
               tap[i] <= '0;
            else if (en) begin
               if (i == 0) tap[i] <= smp_in;
               else        tap[i] <= tap[(i == 0) ? 0 : i - 1];
            end
         end
      end
   endgenerate

   always_comb begin
      full_prod = tap[LAG-1] * smp_in;
      shifted   = full_prod >>> PROD_SHIFT;
      prod_out  = OUT_W'(shifted);
   end

   // the oldest tap only moves when a sample is accepted
   assert_tap_hold_R2: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(tap[LAG-1]));

endmodule

// File: rtl/afsk_iir_lp.sv
module afsk_iir_lp #(
   parameter int W = 16
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                en,
   input  logic                narrow_fb,
   input  logic signed [W-1:0] x_in,
   output logic signed [W-1:0] y_next
);
   logic signed [W-1:0] x_q;
   logic signed [W-1:0] y_q;
   logic signed [W-1:0] fb_term;

   always_comb begin
      if (narrow_fb)
         fb_term = y_q >>> 1;
      else
         fb_term = (y_q >>> 1) + (y_q >>> 3) + (y_q >>> 5);
      y_next = x_q + x_in + fb_term;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         x_q <= '0;
         y_q <= '0;
      end else if (en) begin
         x_q <= x_in;
         y_q <= y_next;
      end
   end

   assert_state_hold_R2: assert property (@(posedge clk) disable iff (rst)
      !en |=> ($stable(y_q) && $stable(x_q)));

endmodule

// File: rtl/afsk_bit_sync.sv
module afsk_bit_sync
   import afsk_demod_pkg::*;
#(
   parameter int W           = 16,
   parameter int SPB         = 8,
   parameter int PHASE_STEP  = 8,
   parameter int PHASE_NUDGE = 1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                en,
   input  logic signed [W-1:0] y_in,
   output logic                bit_valid,
   output logic                bit_out
);
   localparam int PHASE_MAX  = SPB * PHASE_STEP;
   localparam int PHASE_HALF = PHASE_MAX / 2;
   localparam int PW         = $clog2(PHASE_MAX + PHASE_STEP + PHASE_NUDGE);

   logic [2:0]    hist_q, hist_nx;
   logic [PW-1:0] phase_q, ph_adj, ph_sum, phase_nx;
   logic          slice, edge_seen, wrap, decision, last_dec_q;

   always_comb begin
      slice     = (y_in > 0);
      hist_nx   = {hist_q[1:0], slice};
      edge_seen = hist_nx[0] ^ hist_nx[1];
      if (!edge_seen)
         ph_adj = phase_q;
      else if (phase_q < PW'(PHASE_HALF))
         ph_adj = phase_q + PW'(PHASE_NUDGE);
      else
         ph_adj = phase_q - PW'(PHASE_NUDGE);
      ph_sum   = ph_adj + PW'(PHASE_STEP);
      wrap     = (ph_sum >= PW'(PHASE_MAX));
      phase_nx = wrap ? ph_sum - PW'(PHASE_MAX) : ph_sum;
      decision = vote3(hist_nx);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         hist_q     <= '0;
         phase_q    <= '0;
         last_dec_q <= 1'b0;
         bit_valid  <= 1'b0;
         bit_out    <= 1'b0;
      end else begin
         bit_valid <= 1'b0;
         if (en) begin
            hist_q  <= hist_nx;
            phase_q <= phase_nx;
            if (wrap) begin
               bit_valid  <= 1'b1;
               bit_out    <= (decision == last_dec_q);
               last_dec_q <= decision;
            end
         end
      end
   end

   assert_strobe_after_enable_R2: assert property (@(posedge clk) disable iff (rst)
      bit_valid |-> $past(en));

   assert_phase_in_range_R7: assert property (@(posedge clk) disable iff (rst)
      phase_q < PW'(PHASE_MAX));

   assert_phase_idle_R7: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(phase_q));

   assert_strobe_one_cycle_R9: assert property (@(posedge clk) disable iff (rst)
      bit_valid |=> !bit_valid);

   assert_out_holds_R9: assert property (@(posedge clk) disable iff (rst)
      !bit_valid |-> $stable(bit_out));

endmodule

// File: rtl/afsk_demod_sync.sv
module afsk_demod_sync #(
   parameter int SAMPLE_W    = 8,
   parameter int STATE_W     = 16,
   parameter int SPB         = 8,
   parameter int PROD_SHIFT  = 2,
   parameter int PHASE_STEP  = 8,
   parameter int PHASE_NUDGE = 1
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       smp_en,
   input  logic signed [SAMPLE_W-1:0] smp_in,
   input  logic                       fb_sel,
   output logic                       bit_valid,
   output logic                       bit_out
);
   localparam int LAG = SPB / 2;

   generate
      if (SPB < 2 || (SPB % 2) != 0)
         $error("samples per bit must be even and at least 2");
      if (STATE_W < 2 * SAMPLE_W)
         $error("filter state narrower than the full product");
      if (PHASE_STEP + PHASE_NUDGE >= SPB * PHASE_STEP)
         $error("phase step plus nudge must stay below one bit period");
      if (PHASE_NUDGE >= PHASE_STEP)
         $error("nudge must be smaller than the per-sample step");
   endgenerate

   logic signed [STATE_W-1:0] disc;
   logic signed [STATE_W-1:0] filt;

   afsk_delay_mult #(
      .SAMPLE_W  (SAMPLE_W),
      .LAG       (LAG),
      .PROD_SHIFT(PROD_SHIFT),
      .OUT_W     (STATE_W)
   ) u_disc (
      .clk     (clk),
      .rst     (rst),
      .en      (smp_en),
      .smp_in  (smp_in),
      .prod_out(disc)
   );

   afsk_iir_lp #(
      .W(STATE_W)
   ) u_lp (
      .clk      (clk),
      .rst      (rst),
      .en       (smp_en),
      .narrow_fb(fb_sel),
      .x_in     (disc),
      .y_next   (filt)
   );

   afsk_bit_sync #(
      .W          (STATE_W),
      .SPB        (SPB),
      .PHASE_STEP (PHASE_STEP),
      .PHASE_NUDGE(PHASE_NUDGE)
   ) u_sync (
      .clk      (clk),
      .rst      (rst),
      .en       (smp_en),
      .y_in     (filt),
      .bit_valid(bit_valid),
      .bit_out  (bit_out)
   );

endmodule

// File: tb/afsk_demod_sync_test.sv
module afsk_demod_sync_test;
   logic             clk = 1'b0;
   logic             rst;
   logic             smp_en;
   logic signed [7:0] smp_in;
   logic             fb_sel;
   logic             bit_valid;
   logic             bit_out;

   always #5 clk = ~clk;

   afsk_demod_sync uut (
      .clk      (clk),
      .rst      (rst),
      .smp_en   (smp_en),
      .smp_in   (smp_in),
      .fb_sel   (fb_sel),
      .bit_valid(bit_valid),
      .bit_out  (bit_out)
   );

   int n_checks = 0;
   int n_fail   = 0;

   // independent model built from the requirements
   int       m_dly [4];
   int       m_x, m_y, m_ph;
   bit [2:0] m_hist;
   bit       m_prev, exp_valid, exp_bit;
   int       smp_idx, first_strobe;

   function automatic void model_reset();
      for (int i = 0; i < 4; i++) m_dly[i] = 0;
      m_x = 0; m_y = 0; m_ph = 0; m_hist = 3'b000;
      m_prev = 1'b0; exp_valid = 1'b0; exp_bit = 1'b0;
   endfunction

   function automatic void model_step(input int s, input bit fb);
      int  prod, yn;
      bit  sl, edg, dec;
      prod = (m_dly[3] * s) >>> 2;                         // R3
      for (int i = 3; i > 0; i--) m_dly[i] = m_dly[i-1];
      m_dly[0] = s;
      if (fb) yn = m_x + prod + (m_y >>> 1);               // R5
      else    yn = m_x + prod + (m_y >>> 1) + (m_y >>> 3) + (m_y >>> 5); // R4
      yn  = int'(shortint'(yn));
      m_x = prod; m_y = yn;
      sl  = (yn > 0);                                      // R6
      m_hist = {m_hist[1:0], sl};
      edg = m_hist[0] ^ m_hist[1];
      if (edg) m_ph = (m_ph < 32) ? m_ph + 1 : m_ph - 1;   // R7
      m_ph += 8;
      exp_valid = 1'b0;
      if (m_ph >= 64) begin
         m_ph -= 64;
         exp_valid = 1'b1;
         dec = ($countones(m_hist) >= 2);                  // R8
         exp_bit = (dec == m_prev);                        // R9
         m_prev = dec;
      end
   endfunction

   task automatic check_eq(input string tag, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // called at a negedge; returns at the next negedge after checking
   task automatic push(input int s, input string tag);
      smp_in = 8'(s);
      smp_en = 1'b1;
      model_step(s, fb_sel);
      smp_idx++;
      @(negedge clk);
      smp_en = 1'b0;
      check_eq(tag, "bit_valid", int'(bit_valid), int'(exp_valid));
      if (exp_valid) begin
         if (first_strobe < 0) first_strobe = smp_idx;
         check_eq(tag, "bit_out", int'(bit_out), int'(exp_bit));
      end
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         check_eq(tag, "bit_valid on idle cycle", int'(bit_valid), 0);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1; smp_en = 1'b0; smp_in = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      model_reset();
      smp_idx = 0; first_strobe = -1;
      @(negedge clk);
   endtask

   // two-tone stream, differential coding of random data
   task automatic fsk_run(input int nbits, input int amp, input int lead, input string tag);
      real ph = 0.0;
      real inc;
      bit  tone_hi = 1'b0;
      bit [15:0] lf = 16'hACE1;
      for (int i = 0; i < lead; i++) push(0, tag);
      for (int b = 0; b < nbits; b++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         if (!lf[0]) tone_hi = ~tone_hi;
         inc = tone_hi ? (2.0 * 3.14159265 * 2200.0 / 9600.0)
                       : (2.0 * 3.14159265 * 1200.0 / 9600.0);
         for (int k = 0; k < 8; k++) begin
            ph += inc;
            push($rtoi(amp * $sin(ph)), tag);
         end
      end
   endtask

   initial begin
      #1500000;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      fb_sel = 1'b0;
      do_reset();
      // R1 reset state
      check_eq("R1", "bit_valid after reset", int'(bit_valid), 0);
      check_eq("R1", "bit_out after reset", int'(bit_out), 0);

      // silence: free-running bit clock, repeated line bit 0
      for (int i = 0; i < 40; i++) push(0, "R1 R9");
      check_eq("R1", "first strobe sample index", first_strobe, 8);

      // constant positive and extreme negative inputs
      do_reset();
      for (int i = 0; i < 40; i++) push(100, "R3 R6");
      do_reset();
      for (int i = 0; i < 40; i++) push(-128, "R3");
      do_reset();
      for (int i = 0; i < 48; i++) push((i % 2) ? 127 : -128, "R3 R6");
      do_reset();
      for (int i = 0; i < 64; i++) push(((i / 3) % 2) ? 90 : -70, "R6 R7");

      // two-tone data, default feedback, several offsets and amplitudes
      do_reset();
      fsk_run(300, 100, 3, "R4 R7 R8 R9");
      do_reset();
      fsk_run(200, 127, 5, "R4 R8");
      do_reset();
      fsk_run(200, 40, 0, "R7 R9");

      // alternate feedback mode
      fb_sel = 1'b1;
      do_reset();
      fsk_run(300, 100, 3, "R5 R8 R9");
      do_reset();
      for (int i = 0; i < 40; i++) push(-100, "R5");
      fb_sel = 1'b0;

      // random samples with random idle gaps
      do_reset();
      begin
         bit [15:0] lf = 16'h1D0F;
         for (int i = 0; i < 2000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            push($signed(lf[7:0]), "R2");
            if (lf[9]) idle(int'(lf[11:10]) + 1, "R2");
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule